// File: doc/BRIEF.md
# Address Window Decoder with Bus-Error Flags

This block watches a shared request path and decides which of several attached responder slots owns each request. The address map is cut into equal windows of K = 2^WIN_BITS locations. Window i covers addresses i*K up to (i+1)*K-1. The high address bits pick the window. The low WIN_BITS bits are handed to the chosen slot as its local offset.

Every responder sees every request. A slot is selected only when all of these hold:

- the address lies inside its window;
- its slot is wired into the build;
- its per-slot present input is high.

Two kinds of fault are reported on registered one-cycle pulses in the cycle after the request:

- **Conflict:** two or more responders acknowledge the same request.
- **Unmapped:** a request lands on no selected slot. This covers gaps in the map, unwired or empty slots, and addresses beyond the last window.

Top module: `addr_window_decoder`

## Requirements
- R1: While `req_valid` is high, `slot_sel[i]` is high exactly when `req_addr[ADDR_W-1:WIN_BITS]` equals i, i < POP_SLOTS and `slot_present[i]` is high. At most one bit of `slot_sel` is ever high.
- R2: `slot_offset` equals `req_addr[WIN_BITS-1:0]` when some slot is selected, and is zero when none is.
- R3: A request that selects no slot raises `err_unmapped` in the following cycle. This holds for an address past window NUM_SLOTS-1, for a window at or above POP_SLOTS, and for a window whose present bit is low.
- R4: A request during which two or more bits of `resp_ack` are high raises `err_conflict` in the following cycle.
- R5: A request with zero or one `resp_ack` bit high leaves `err_conflict` low in the following cycle.
- R6: While `req_valid` is low, `slot_sel` is all zero, `slot_offset` is zero, and neither error rises in the next cycle, whatever the address and acknowledges.
- R7: During reset and in the first cycle after it, both error outputs are low.
- R8: A single request can raise both errors together.
- R9: Each error pulse lasts one cycle. In back-to-back requests, each cycle's error value reflects only the request of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is on the bus this cycle |
| req_addr | input | ADDR_W | Request address |
| slot_present | input | NUM_SLOTS | Per-slot populated mask |
| resp_ack | input | NUM_SLOTS | Per-slot responder acknowledge |
| slot_sel | output | NUM_SLOTS | One-hot slot select (combinational) |
| slot_offset | output | WIN_BITS | Offset within the selected window |
| err_conflict | output | 1 | Registered pulse: multiple responders answered |
| err_unmapped | output | 1 | Registered pulse: no slot owns the address |

## Verification
The vector table covers the following address patterns:

- the first and last location of a window, which separates an off-by-one window boundary from a correct one;
- addresses in unwired windows and beyond the map, which separates true gaps from aliasing on the low index bits;
- a populated window with its present bit cleared, which shows the mask is honoured.

Acknowledge patterns of none, one, two, and two outside the selected slot separate the multi-responder check from a plain select test. Consecutive vectors run back-to-back and an idle cycle follows, so a stretched or stuck error pulse is told apart from a one-cycle one.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // Registered error state of the decoder
    typedef struct packed {
        logic conflict;
        logic unmapped;
    } awd_err_t;

    localparam awd_err_t AWD_ERR_NONE = '{conflict: 1'b0, unmapped: 1'b0};

endpackage

// File: rtl/awd_window_match.sv
// Compares the window index of a request with one slot's fixed index.
module awd_window_match #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 10,
    parameter int SLOT_IDX = 0,
    parameter bit WIRED    = 1'b1
) (
    input  logic                         req_valid,
    input  logic                         present,
    input  logic [ADDR_W-WIN_BITS-1:0]   upper,
    output logic                         hit
);
    localparam int UP_W = ADDR_W - WIN_BITS;
    localparam logic [UP_W-1:0] MY_UPPER = UP_W'(SLOT_IDX);

    always_comb begin
        hit = WIRED & req_valid & present & (upper == MY_UPPER);
    end
endmodule

// File: rtl/awd_multi_detect.sv
// Flags two or more set bits without building a full population count.
module awd_multi_detect #(
    parameter int N = 8
) (
    input  logic [N-1:0] vec,
    output logic         multi
);
    logic seen;

    always_comb begin
        seen  = 1'b0;
        multi = 1'b0;
        for (int i = 0; i < N; i++) begin
            multi = multi | (seen & vec[i]);
            seen  = seen | vec[i];
        end
    end
endmodule

// File: rtl/awd_offset_slice.sv
// Forwards the in-window offset only while a slot owns the request.
module awd_offset_slice #(
    parameter int WIN_BITS = 10
) (
    input  logic [WIN_BITS-1:0] low_addr,
    input  logic                any_hit,
    output logic [WIN_BITS-1:0] offset
);
    always_comb begin
        offset = any_hit ? low_addr : '0;
    end
endmodule

// File: rtl/addr_window_decoder.sv
// Equal-window address decoder with conflict and unmapped-address pulses.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_BITS  = 10,
    parameter int NUM_SLOTS = 8,
    parameter int POP_SLOTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [NUM_SLOTS-1:0] slot_present,
    input  logic [NUM_SLOTS-1:0] resp_ack,
    output logic [NUM_SLOTS-1:0] slot_sel,
    output logic [WIN_BITS-1:0]  slot_offset,
    output logic                 err_conflict,
    output logic                 err_unmapped
);
    localparam int UP_W = ADDR_W - WIN_BITS;

    logic [UP_W-1:0]      addr_upper;
    logic [NUM_SLOTS-1:0] hit_vec;
    logic                 any_hit;
    logic                 multi_ack;
    awd_err_t             err_d;
    awd_err_t             err_q;

    assign addr_upper = req_addr[ADDR_W-1:WIN_BITS];

    // One comparator per window; windows at or above POP_SLOTS are holes
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        awd_window_match #(
            .ADDR_W   (ADDR_W),
            .WIN_BITS (WIN_BITS),
            .SLOT_IDX (i),
            .WIRED    ((i < POP_SLOTS) ? 1'b1 : 1'b0)
        ) u_win (
            .req_valid (req_valid),
            .present   (slot_present[i]),
            .upper     (addr_upper),
            .hit       (hit_vec[i])
        );
    end

    assign any_hit  = |hit_vec;
    assign slot_sel = hit_vec;

    awd_offset_slice #(
        .WIN_BITS (WIN_BITS)
    ) u_off (
        .low_addr (req_addr[WIN_BITS-1:0]),
        .any_hit  (any_hit),
        .offset   (slot_offset)
    );

    awd_multi_detect #(
        .N (NUM_SLOTS)
    ) u_multi (
        .vec   (resp_ack),
        .multi (multi_ack)
    );

    // Next error state: each flag reflects only the current request
    always_comb begin
        err_d          = AWD_ERR_NONE;
        err_d.conflict = req_valid & multi_ack;
        err_d.unmapped = req_valid & ~any_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= AWD_ERR_NONE;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_conflict = err_q.conflict;
    assign err_unmapped = err_q.unmapped;
endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int WIN_BITS  = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [NUM_SLOTS-1:0] resp_ack,
    input logic [NUM_SLOTS-1:0] slot_sel,
    input logic [WIN_BITS-1:0]  slot_offset,
    input logic                 err_conflict,
    input logic                 err_unmapped
);
    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));

    // R6
    idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (slot_sel == '0));

    // R2
    offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_sel == '0) |-> (slot_offset == '0));

    // R3
    unmapped_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && slot_sel == '0) |=> err_unmapped);

    // R9
    unmapped_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && slot_sel == '0) |=> !err_unmapped);

    // R4
    conflict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $countones(resp_ack) > 1) |=> err_conflict);

    // R5
    no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && $countones(resp_ack) > 1) |=> !err_conflict);

    // R7
    reset_release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!err_conflict && !err_unmapped));
endmodule

bind addr_window_decoder awd_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .WIN_BITS  (WIN_BITS)
) u_chk (.*);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
    localparam int ADDR_W = 16;
    localparam int WB     = 10;
    localparam int NS     = 8;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  pres;
        logic [7:0]  ack;
        logic [7:0]  sel;
        logic [9:0]  off;
        logic        conf;
        logic        unm;
    } vec_t;

    // K = 1024, slots 0..5 wired, slots 6..7 are holes, map ends at 0x2000
    localparam vec_t VECS [12] = '{
        '{16'h0000, 8'hFF, 8'h01, 8'h01, 10'h000, 1'b0, 1'b0}, // R1 first loc
        '{16'h03FF, 8'hFF, 8'h01, 8'h01, 10'h3FF, 1'b0, 1'b0}, // R1 last loc
        '{16'h0400, 8'hFF, 8'h02, 8'h02, 10'h000, 1'b0, 1'b0}, // R1 next window
        '{16'h17FF, 8'hFF, 8'h20, 8'h20, 10'h3FF, 1'b0, 1'b0}, // R1 top wired
        '{16'h1800, 8'hFF, 8'h00, 8'h00, 10'h000, 1'b0, 1'b1}, // R3 unwired
        '{16'h2000, 8'hFF, 8'h00, 8'h00, 10'h000, 1'b0, 1'b1}, // R3 beyond map
        '{16'hFFFF, 8'hFF, 8'h00, 8'h00, 10'h000, 1'b0, 1'b1}, // R3 top address
        '{16'h0C12, 8'hF7, 8'h00, 8'h00, 10'h000, 1'b0, 1'b1}, // R3 empty slot
        '{16'h0C12, 8'hFF, 8'h0C, 8'h08, 10'h012, 1'b1, 1'b0}, // R4 two acks, R9
        '{16'h0855, 8'hFF, 8'h00, 8'h04, 10'h055, 1'b0, 1'b0}, // R5 no ack
        '{16'h1C00, 8'hFF, 8'h81, 8'h00, 10'h000, 1'b1, 1'b1}, // R8 both
        '{16'h1234, 8'hFF, 8'h10, 8'h10, 10'h234, 1'b0, 1'b0}  // R2 R5 R9
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [NS-1:0]     slot_present = '0;
    logic [NS-1:0]     resp_ack = '0;
    logic [NS-1:0]     slot_sel;
    logic [WB-1:0]     slot_offset;
    logic              err_conflict;
    logic              err_unmapped;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    addr_window_decoder #(
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WB),
        .NUM_SLOTS (NS),
        .POP_SLOTS (6)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .slot_present (slot_present),
        .resp_ack     (resp_ack),
        .slot_sel     (slot_sel),
        .slot_offset  (slot_offset),
        .err_conflict (err_conflict),
        .err_unmapped (err_unmapped)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: quiet during reset
        repeat (3) @(posedge clk);
        #1;
        check("R7 conflict in reset", 32'(err_conflict), 32'd0);
        check("R7 unmapped in reset", 32'(err_unmapped), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R7 conflict after reset", 32'(err_conflict), 32'd0);
        check("R7 unmapped after reset", 32'(err_unmapped), 32'd0);

        // Vector table, requests back-to-back
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            req_valid    = 1'b1;
            req_addr     = VECS[v].addr;
            slot_present = VECS[v].pres;
            resp_ack     = VECS[v].ack;
            #1;
            check($sformatf("R1 sel vec%0d", v), 32'(slot_sel), 32'(VECS[v].sel));
            check($sformatf("R2 offset vec%0d", v), 32'(slot_offset), 32'(VECS[v].off));
            @(posedge clk);
            #1;
            check($sformatf("R4 R5 R8 conflict vec%0d", v), 32'(err_conflict), 32'(VECS[v].conf));
            check($sformatf("R3 R9 unmapped vec%0d", v), 32'(err_unmapped), 32'(VECS[v].unm));
        end

        // R6: idle with a hole address and every ack high
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 16'h2000;
        resp_ack  = 8'hFF;
        #1;
        check("R6 idle sel", 32'(slot_sel), 32'd0);
        check("R6 idle offset", 32'(slot_offset), 32'd0);
        @(posedge clk);
        #1;
        check("R6 R9 idle conflict", 32'(err_conflict), 32'd0);
        check("R6 R9 idle unmapped", 32'(err_unmapped), 32'd0);

        // R6: idle on a mapped address also selects nothing
        @(negedge clk);
        req_addr = 16'h0401;
        resp_ack = 8'h00;
        #1;
        check("R6 idle mapped sel", 32'(slot_sel), 32'd0);

        // R9: single unmapped request then idle: pulse lasts one cycle
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 16'h3000;
        @(posedge clk);
        #1;
        check("R3 single unmapped", 32'(err_unmapped), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R9 pulse dropped", 32'(err_unmapped), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule